// File: doc/BRIEF.md
# Big-Endian Aligned Load/Store Unit

This block is the data-memory access stage of a 32-bit core, together with its own byte-addressed storage. A request carries a base register value, a signed 16-bit displacement, an access size and a direction. The unit forms the effective address, checks that it is aligned for the access size, and then either writes the selected byte lanes of the addressed word or returns a zero-extended load result one clock later.

Bytes are ordered most-significant-first. The byte at the lowest address of a word occupies bits 31:24 of the register image. Stores drive a four-bit lane enable vector, with one bit per byte of the addressed word. A request that breaks the alignment rule raises a one-cycle fault flag and has no effect on the storage. A load that breaks the rule returns zero.

Top module: `be_lsu`

## Requirements
- R1: While `rst_n` is low, every storage byte is cleared and `load_valid`, `fault`, `load_data` and `byte_we` read zero.
- R2: The effective address is `base` plus `offset` sign-extended to 32 bits. Only its low log2(MEM_BYTES) bits select a byte, so the storage wraps modulo its depth.
- R3: Byte order is most-significant-first. A word stored at A places bits 31:24 at A and bits 7:0 at A+3, and a word load rebuilds it the same way. `req_size` encodes 00 as byte, 01 as half-word, and 10 or 11 as word.
- R4: An aligned half-word store drives `byte_we` 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1, writing `store_data[15:0]` most-significant byte first. `byte_we[3]` is the lane at word offset 0.
- R5: An aligned byte store drives exactly one `byte_we` bit, namely bit 3 minus address bits [1:0], and writes `store_data[7:0]`. An aligned word store drives 4'b1111.
- R6: Byte and half-word loads return the addressed byte or pair in the low bits of `load_data`, with all upper bits zero.
- R7: A word access whose address bits [1:0] are not 00, and a half-word access whose address bit 0 is 1, is misaligned. Byte accesses are never misaligned. `fault` is high in exactly the cycle after a misaligned request.
- R8: A misaligned store drives `byte_we` to zero and changes no stored byte.
- R9: A misaligned load still raises `load_valid` one cycle later, with `load_data` zero.
- R10: `load_valid` is high exactly in the cycle after a load request. `load_data` is zero in every cycle where `load_valid` is low.
- R11: Reading a byte that has not been written since reset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half-word, 1x word |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Store operand, right-aligned for narrow stores |
| load_data | output | 32 | Load result, zero-extended |
| load_valid | output | 1 | Qualifies `load_data`, one cycle after a load request |
| fault | output | 1 | Misalignment flag, one cycle after the request |
| byte_we | output | 4 | Lane write enables of the addressed word, bit 3 = lowest address |

## Verification
The hardest behaviour to reach from the ports is a mix of lane overlap and address wrap. In that case, narrow stores land in parts of a word that earlier, wider stores had filled, and addresses formed from negative displacements or large bases fold back into the same storage. The random stream keeps bases within a few times the storage depth and displacements small and signed, so collisions, wrap-around and misaligned sizes occur often. A byte-level reference model then predicts every lane enable and every load. Directed cases cover the ordering example, unwritten bytes, and a blocked misaligned store that is read back afterwards.

// File: rtl/be_lsu.sv
module be_lsu #(
  parameter int MEM_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic [31:0] base,
  input  logic [15:0] offset,
  input  logic [31:0] store_data,
  output logic [31:0] load_data,
  output logic        load_valid,
  output logic        fault,
  output logic [3:0]  byte_we
);
  localparam int AW = $clog2(MEM_BYTES);

  logic [7:0] mem [MEM_BYTES];

  wire [31:0]   ea      = base + {{16{offset[15]}}, offset};
  wire          is_word = req_size[1];
  wire          is_half = (req_size == 2'b01);
  wire          misal   = (is_word && ea[1:0] != 2'b00) || (is_half && ea[0]);
  wire [AW-3:0] widx    = ea[AW-1:2];
  wire          do_st   = req_valid && req_store && !misal;
  wire          do_ld   = req_valid && !req_store && !misal;

  assign byte_we = !do_st   ? 4'b0000 :
                   is_word  ? 4'b1111 :
                   is_half  ? (4'b1100 >> {ea[1], 1'b0}) :
                              (4'b1000 >> ea[1:0]);

  wire [31:0] wdat = is_word ? store_data :
                     is_half ? {2{store_data[15:0]}} : {4{store_data[7:0]}};

  wire [31:0] rword = {mem[{widx, 2'd0}], mem[{widx, 2'd1}],
                       mem[{widx, 2'd2}], mem[{widx, 2'd3}]};

  logic [7:0] rbyte;
  always_comb begin
    case (ea[1:0])
      2'd0:    rbyte = rword[31:24];
      2'd1:    rbyte = rword[23:16];
      2'd2:    rbyte = rword[15:8];
      default: rbyte = rword[7:0];
    endcase
  end

  wire [31:0] rdat = is_word ? rword :
                     is_half ? {16'h0, (ea[1] ? rword[15:0] : rword[31:16])} :
                               {24'h0, rbyte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
      load_valid <= 1'b0;
      fault      <= 1'b0;
      load_data  <= 32'h0;
    end else begin
      load_valid <= req_valid && !req_store;
      fault      <= req_valid && misal;
      load_data  <= do_ld ? rdat : 32'h0;
      for (int k = 0; k < 4; k++)
        if (byte_we[3-k]) mem[{widx, 2'(k)}] <= wdat[8*(3-k) +: 8];
    end
  end

  // R7
  fault_after_misal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && misal) |=> fault);
  // R7
  fault_only_after_misal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req_valid && misal));
  // R8
  misal_store_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && misal) |-> (byte_we == 4'b0000));
  // R4
  half_two_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && is_half && !misal) |-> ($countones(byte_we) == 2));
  // R5
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'b00) |-> $onehot(byte_we));
  // R10
  valid_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(req_valid && !req_store));
  // R10
  data_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> (load_data == 32'h0));
  // R6
  byte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && $past(req_size == 2'b00)) |-> (load_data[31:8] == 24'h0));
  // R9
  misal_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && fault) |-> (load_data == 32'h0));
endmodule

// File: tb/be_lsu_bench.sv
module be_lsu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base = 32'h0, store_data = 32'h0;
  logic [15:0] offset = 16'h0;
  logic [31:0] load_data;
  logic        load_valid, fault;
  logic [3:0]  byte_we;

  int tests = 0, fails = 0;
  logic [7:0] mdl [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  be_lsu #(.MEM_BYTES(DEPTH)) u_be_lsu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .base(base), .offset(offset), .store_data(store_data),
    .load_data(load_data), .load_valid(load_valid), .fault(fault), .byte_we(byte_we));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_misal(input logic [1:0] sz, input logic [31:0] a);
    return (sz[1] && a[1:0] != 2'b00) || (sz == 2'b01 && a[0]);
  endfunction

  function automatic logic [3:0] exp_we(input logic st, input logic [1:0] sz, input logic [31:0] a);
    logic [3:0] w = 4'b0000;
    if (!st || is_misal(sz, a)) return w;
    if (sz[1]) return 4'b1111;
    if (sz == 2'b01) begin
      w[3 - {a[1], 1'b0}] = 1'b1;
      w[2 - {a[1], 1'b0}] = 1'b1;
      return w;
    end
    w[3 - a[1:0]] = 1'b1;
    return w;
  endfunction

  function automatic logic [7:0] mb(input logic [31:0] a);
    return mdl[a[9:0]];
  endfunction

  function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic [31:0] a);
    if (is_misal(sz, a)) return 32'h0;
    if (sz[1]) return {mb(a), mb(a + 1), mb(a + 2), mb(a + 3)};
    if (sz == 2'b01) return {16'h0, mb(a), mb(a + 1)};
    return {24'h0, mb(a)};
  endfunction

  task automatic op(input logic st, input logic [1:0] sz, input logic [31:0] b,
                    input logic [15:0] off, input logic [31:0] sd, input string tag);
    logic [31:0] a = b + {{16{off[15]}}, off};
    logic [3:0]  we = exp_we(st, sz, a);
    logic [31:0] ld = st ? 32'h0 : exp_ld(sz, a);
    bit          mis = is_misal(sz, a);
    req_valid = 1'b1; req_store = st; req_size = sz; base = b; offset = off; store_data = sd;
    #1;
    check(byte_we == we, {tag, " byte_we"}, {28'h0, byte_we}, {28'h0, we});
    @(negedge clk);
    check(load_valid == !st, {tag, " R10 load_valid"}, {31'h0, load_valid}, {31'h0, !st});
    check(fault == mis, {tag, " R7 fault"}, {31'h0, fault}, {31'h0, mis});
    check(load_data == ld, {tag, " load_data"}, load_data, ld);
    for (int k = 0; k < 4; k++)
      if (we[3-k])
        mdl[(a[9:0] & 10'h3FC) + k] = sz[1] ? sd[8*(3-k) +: 8] :
                                      sz == 2'b01 ? ((k % 2 == 0) ? sd[15:8] : sd[7:0]) : sd[7:0];
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0; req_store = 1'b0;
    #1;
    check(byte_we == 4'b0, {tag, " R8 idle we"}, {28'h0, byte_we}, 32'h0);
    @(negedge clk);
    check(!load_valid && !fault && load_data == 32'h0, {tag, " R10 idle outputs"},
          {load_data[29:0], load_valid, fault}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check(load_valid == 0 && fault == 0 && load_data == 0 && byte_we == 0, "R1 reset outputs",
          {load_data[27:0], byte_we}, 32'h0);
    rst_n = 1'b1;

    op(1'b0, 2'b10, 32'h200, 16'h0, 0, "R11 unwritten word");
    op(1'b0, 2'b00, 32'h3FF, 16'h0, 0, "R1 R11 unwritten byte");
    op(1'b1, 2'b10, 32'h100, 16'h0, 32'h01234567, "R3 word store");
    for (int k = 0; k < 4; k++) op(1'b0, 2'b00, 32'h100, 16'(k), 0, "R3 R6 byte order");
    op(1'b0, 2'b10, 32'h108, 16'hFFF8, 0, "R2 negative offset");
    op(1'b0, 2'b01, 32'h102, 16'h0, 0, "R6 half low");
    op(1'b1, 2'b10, 32'h44, 16'h0, 32'h5, "R3 store five");
    op(1'b0, 2'b00, 32'h40, 16'h4, 0, "R2 R11 offset four");
    op(1'b0, 2'b00, 32'h40, 16'h7, 0, "R2 offset seven");
    op(1'b1, 2'b10, 32'h101, 16'h0, 32'hDEADBEEF, "R8 misaligned word store");
    idle("R7 fault drops");
    op(1'b0, 2'b10, 32'h100, 16'h0, 0, "R8 store blocked");
    op(1'b1, 2'b01, 32'h103, 16'h0, 32'hAAAA, "R8 misaligned half store");
    op(1'b0, 2'b10, 32'h102, 16'h0, 0, "R9 misaligned load");
    op(1'b0, 2'b01, 32'h101, 16'h0, 0, "R9 misaligned half load");
    op(1'b1, 2'b01, 32'h102, 16'h0, 32'hFFFFBEEF, "R4 half store high lanes");
    op(1'b1, 2'b01, 32'h100, 16'h0, 32'h1234, "R4 half store low lanes");
    op(1'b1, 2'b00, 32'h101, 16'h0, 32'hFFFFFF99, "R5 byte store");
    op(1'b1, 2'b00, 32'h103, 16'h0, 32'h77, "R5 odd byte store");
    op(1'b0, 2'b10, 32'h100, 16'h0, 0, "R4 R5 word readback");
    op(1'b0, 2'b10, 32'h500, 16'h0, 0, "R2 wrap to 0x100");
    idle("R10 idle");

    for (int n = 0; n < 600; n++) begin
      logic        st = 1'($urandom);
      logic [1:0]  sz = 2'($urandom);
      logic [31:0] b  = $urandom % 4096;
      logic [15:0] of = 16'($urandom % 64) - 16'd32;
      op(st, sz, b, of, $urandom, "R2 R3 R6 random");
      if ($urandom % 8 == 0) idle("R10 random idle");
    end
    idle("R10 final");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule